// File: doc/BRIEF.md
# Fractional Rate Clock Enable Generator

This block turns a fast input clock into a stream of single-cycle enable pulses whose average rate is n/m of the input rate, where n ≤ m. It can also drive a divided clock level. The rate comes from two signed coefficients. One is a positive step equal to m − n. The other is a negative step equal to −n. Both may be scaled by the same power of two. The negative step is held in the configuration word as its low bits only, and the sign is implied. Every cycle a small accumulator tries the negative step. When that step would make the accumulator negative, the accumulator takes the positive step instead and an enable pulse is issued. So pulses come from the positive-step branch, and over m cycles exactly n of them occur.

A stretch option turns the divided-clock output from a copy of the enable into a level that stays high for about half of each average output period. The divided clock is high while the next accumulator value lies in the upper half of its range [0, m). The whole configuration is one packed word. The coefficients and the stretch option are captured only while the run bit is clear. Rewriting them during operation therefore cannot disturb the outputs. Computing the coefficients from m and n is left to the user.

Top module: `frac_clk_div`

## Requirements
- R1: The configuration word of width 2·FIELD_W+2 holds the positive step in bits [FIELD_W-1:0], the negative step's low FIELD_W bits in bits [2·FIELD_W-1:FIELD_W], the stretch bit at 2·FIELD_W and the run bit at 2·FIELD_W+1. The negative-step field f encodes n = 2^FIELD_W − f; for example, with FIELD_W = 8, field 0xF4 means −12.
- R2: With run set, `clk_en` is high in exactly n of every m consecutive cycles, where m = positive step + n. For example, step 1 and field 0xF4 give 12 pulses in 13 cycles, and step 3 and field 0xFF give the pattern 1,0,0,0 repeating. The accumulator stays below m.
- R3: Scaling both coefficients by the same power of two leaves the pulse sequence unchanged.
- R4: On the clock edge after an edge that sees run clear, both outputs are low. When run returns, the sequence restarts from phase zero: the first output cycle carries a pulse.
- R5: The coefficients and the stretch bit are captured only on edges where run is clear. Changes made while run stays set have no effect on either output.
- R6: With stretch clear, `div_clk` equals `clk_en` in every cycle.
- R7: With stretch set, `div_clk` rises only in a cycle where `clk_en` is high.
- R8: With stretch set and n, m coprime, `div_clk` is high in exactly ceil(m/2) of every m cycles. For example, n=1 and m=4 gives the pattern 1,1,0,0.
- R9: FIELD_W selects the coefficient width. Both 8 and 13 give the same rate law.
- R10: During and right after reset both outputs are low, and the captured coefficients are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_word | input | 2·FIELD_W+2 | Packed configuration: run, stretch, negative-step field, positive step |
| clk_en | output | 1 | Single-cycle enable pulse at n/m of the input rate |
| div_clk | output | 1 | Divided clock: a copy of the enable, or the stretched level |

## Verification
The bench builds two copies of the block. The first uses FIELD_W = 8 and covers the ratios 12/13, 1/4 and 3/8, including a copy of 12/13 scaled by 16. The second uses FIELD_W = 13; it runs 5/8 both unscaled and scaled by 1024, so the step values need more than eight bits. Short ratios keep a full accumulator cycle within a few dozen clocks. This allows exact pulse and high-time counts, and bit patterns, to be compared over whole periods.

// File: rtl/frac_div_pkg.sv
`timescale 1ns/1ps
package frac_div_pkg;

    typedef enum logic {
        OUT_PULSE   = 1'b0,
        OUT_STRETCH = 1'b1
    } out_mode_e;

    // Bit positions inside the packed configuration word
    function automatic int stretch_pos(int field_w);
        return 2 * field_w;
    endfunction

    function automatic int run_pos(int field_w);
        return 2 * field_w + 1;
    endfunction

endpackage

// File: rtl/frac_cfg_hold.sv
`timescale 1ns/1ps
module frac_cfg_hold
    import frac_div_pkg::*;
#(
    parameter int FIELD_W = 8,
    localparam int CFG_W  = 2 * FIELD_W + 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [CFG_W-1:0]   cfg_word,
    output logic               run_now,
    output logic [FIELD_W-1:0] add_q,
    output logic [FIELD_W-1:0] sub_q,
    output out_mode_e          mode_q
);
    localparam int RUN_BIT = run_pos(FIELD_W);
    localparam int STR_BIT = stretch_pos(FIELD_W);

    assign run_now = cfg_word[RUN_BIT];

    // Coefficients are only sampled while the divider is stopped
    always_ff @(posedge clk) begin
        if (rst) begin
            add_q  <= '0;
            sub_q  <= '0;
            mode_q <= OUT_PULSE;
        end else if (!run_now) begin
            add_q  <= cfg_word[FIELD_W-1:0];
            sub_q  <= cfg_word[2*FIELD_W-1:FIELD_W];
            mode_q <= cfg_word[STR_BIT] ? OUT_STRETCH : OUT_PULSE;
        end
    end
endmodule

// File: rtl/frac_phase_acc.sv
`timescale 1ns/1ps
module frac_phase_acc #(
    parameter int FIELD_W = 8,
    localparam int ACC_W  = FIELD_W + 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               run_now,
    input  logic [FIELD_W-1:0] add_q,
    input  logic [FIELD_W-1:0] sub_q,
    output logic               pulse,
    output logic [ACC_W-1:0]   acc_q,
    output logic [ACC_W-1:0]   acc_nxt,
    output logic [ACC_W-1:0]   m_tot
);
    localparam logic [ACC_W-1:0] FULL_SCALE = ACC_W'(1) << FIELD_W;

    logic [ACC_W-1:0] n_mag;
    logic [ACC_W:0]   trial;
    logic [ACC_W-1:0] with_add;
    logic             borrow;

    // Field is the low bits of a negative number; the sign is implied
    assign n_mag    = FULL_SCALE - {1'b0, sub_q};
    assign m_tot    = {1'b0, add_q} + n_mag;
    assign trial    = {1'b0, acc_q} - {1'b0, n_mag};
    assign borrow   = trial[ACC_W];
    assign with_add = acc_q + {1'b0, add_q};

    always_comb begin
        if (borrow) acc_nxt = with_add;
        else        acc_nxt = trial[ACC_W-1:0];
    end

    assign pulse = run_now & borrow;

    always_ff @(posedge clk) begin
        if (rst || !run_now) acc_q <= '0;
        else                 acc_q <= acc_nxt;
    end
endmodule

// File: rtl/frac_out_stage.sv
`timescale 1ns/1ps
module frac_out_stage
    import frac_div_pkg::*;
#(
    parameter int FIELD_W = 8,
    localparam int ACC_W  = FIELD_W + 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run_now,
    input  out_mode_e        mode_q,
    input  logic             pulse,
    input  logic [ACC_W-1:0] acc_nxt,
    input  logic [ACC_W-1:0] m_tot,
    output logic             en_q,
    output logic             div_q
);
    logic [ACC_W-1:0] half_m;
    logic             upper_half;

    assign half_m     = m_tot >> 1;
    assign upper_half = (acc_nxt >= half_m);

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q  <= 1'b0;
            div_q <= 1'b0;
        end else begin
            en_q <= pulse;
            if (mode_q == OUT_STRETCH) div_q <= run_now & upper_half;
            else                       div_q <= pulse;
        end
    end
endmodule

// File: rtl/frac_clk_div.sv
`timescale 1ns/1ps
module frac_clk_div
    import frac_div_pkg::*;
#(
    parameter int FIELD_W = 8,
    localparam int CFG_W  = 2 * FIELD_W + 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CFG_W-1:0] cfg_word,
    output logic             clk_en,
    output logic             div_clk
);
    localparam int ACC_W = FIELD_W + 1;

    logic               run_now;
    logic [FIELD_W-1:0] add_q;
    logic [FIELD_W-1:0] sub_q;
    out_mode_e          mode_q;
    logic               pulse;
    logic [ACC_W-1:0]   acc_q;
    logic [ACC_W-1:0]   acc_nxt;
    logic [ACC_W-1:0]   m_tot;

    frac_cfg_hold #(.FIELD_W(FIELD_W)) u_cfg (
        .clk(clk), .rst(rst), .cfg_word(cfg_word),
        .run_now(run_now), .add_q(add_q), .sub_q(sub_q), .mode_q(mode_q)
    );

    frac_phase_acc #(.FIELD_W(FIELD_W)) u_acc (
        .clk(clk), .rst(rst), .run_now(run_now),
        .add_q(add_q), .sub_q(sub_q),
        .pulse(pulse), .acc_q(acc_q), .acc_nxt(acc_nxt), .m_tot(m_tot)
    );

    frac_out_stage #(.FIELD_W(FIELD_W)) u_out (
        .clk(clk), .rst(rst), .run_now(run_now), .mode_q(mode_q),
        .pulse(pulse), .acc_nxt(acc_nxt), .m_tot(m_tot),
        .en_q(clk_en), .div_q(div_clk)
    );
endmodule

// File: rtl/frac_clk_div_chk.sv
`timescale 1ns/1ps
module frac_clk_div_chk
    import frac_div_pkg::*;
#(
    parameter int FIELD_W = 8,
    localparam int CFG_W  = 2 * FIELD_W + 2,
    localparam int ACC_W  = FIELD_W + 1
) (
    input logic               clk,
    input logic               rst,
    input logic [CFG_W-1:0]   cfg_word,
    input logic               clk_en,
    input logic               div_clk,
    input out_mode_e          mode_q,
    input logic [FIELD_W-1:0] add_q,
    input logic [ACC_W-1:0]   acc_q,
    input logic [ACC_W-1:0]   m_tot
);
    localparam int RUN_BIT = run_pos(FIELD_W);

    assert_acc_bound_R2: assert property (@(posedge clk) disable iff (rst)
        acc_q < m_tot);

    assert_stop_quiet_R4: assert property (@(posedge clk) disable iff (rst)
        !cfg_word[RUN_BIT] |=> (!clk_en && !div_clk));

    assert_cfg_frozen_R5: assert property (@(posedge clk) disable iff (rst)
        cfg_word[RUN_BIT] |=> ($stable(add_q) && $stable(mode_q)));

    assert_pulse_copy_R6: assert property (@(posedge clk) disable iff (rst)
        (mode_q == OUT_PULSE) |-> (div_clk == clk_en));

    assert_rise_on_pulse_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(div_clk) |-> clk_en);
endmodule

bind frac_clk_div frac_clk_div_chk #(.FIELD_W(FIELD_W)) u_chk (
    .clk(clk), .rst(rst), .cfg_word(cfg_word), .clk_en(clk_en),
    .div_clk(div_clk), .mode_q(mode_q), .add_q(add_q),
    .acc_q(acc_q), .m_tot(m_tot)
);

// File: tb/frac_clk_div_bench.sv
`timescale 1ns/1ps
module frac_clk_div_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [17:0] cfg_n = '0;
    logic [27:0] cfg_w = '0;
    logic        en_n, div_n, en_w, div_w;
    int          n_checks = 0;
    int          n_errors = 0;

    always #2.5 clk = ~clk;

    frac_clk_div #(.FIELD_W(8)) u_frac_clk_div (
        .clk(clk), .rst(rst), .cfg_word(cfg_n), .clk_en(en_n), .div_clk(div_n));

    frac_clk_div #(.FIELD_W(13)) u_frac_clk_div_wide (
        .clk(clk), .rst(rst), .cfg_word(cfg_w), .clk_en(en_w), .div_clk(div_w));

    function automatic logic [17:0] mk(bit run, bit st, logic [7:0] sub, logic [7:0] add);
        return {run, st, sub, add};
    endfunction

    function automatic logic [27:0] mkw(bit run, bit st, logic [12:0] sub, logic [12:0] add);
        return {run, st, sub, add};
    endfunction

    task automatic check(string req, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic check_pat(string req, logic [63:0] act, logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    endtask

    // Stop with the new coefficients so they are captured, then run
    task automatic start_n(logic [17:0] word);
        @(negedge clk) cfg_n = {1'b0, word[16:0]};
        @(negedge clk) cfg_n = word;
    endtask

    task automatic start_w(logic [27:0] word);
        @(negedge clk) cfg_w = {1'b0, word[26:0]};
        @(negedge clk) cfg_w = word;
    endtask

    task automatic sample_n(input int cyc, output int en_cnt, output int div_cnt,
                            output int bad_rise, output int bad_eq,
                            output logic [63:0] epat, output logic [63:0] dpat);
        logic prev;
        prev = div_n;
        en_cnt = 0; div_cnt = 0; bad_rise = 0; bad_eq = 0; epat = '0; dpat = '0;
        for (int i = 0; i < cyc; i++) begin
            @(negedge clk);
            en_cnt  += int'(en_n);
            div_cnt += int'(div_n);
            epat = {epat[62:0], en_n};
            dpat = {dpat[62:0], div_n};
            if (div_n && !prev && !en_n) bad_rise++;
            if (div_n != en_n) bad_eq++;
            prev = div_n;
        end
    endtask

    task automatic sample_w(input int cyc, output int en_cnt);
        en_cnt = 0;
        for (int i = 0; i < cyc; i++) begin
            @(negedge clk);
            en_cnt += int'(en_w);
        end
    endtask

    task automatic t_reset();
        @(negedge clk);
        check("R10 narrow outputs in reset", int'({en_n, div_n}), 0);
        check("R10 wide outputs in reset", int'({en_w, div_w}), 0);
        @(negedge clk) rst = 1'b0;
        @(negedge clk);
        check("R10 outputs after reset", int'({en_n, div_n, en_w, div_w}), 0);
    endtask

    logic [63:0] base_pat;

    task automatic t_rate();
        int e, d, br, be; logic [63:0] ep, dp;
        start_n(mk(1, 0, 8'hF4, 8'h01));
        sample_n(26, e, d, br, be, ep, dp);
        check("R1 R2 12/13 pulses in 26 cycles", e, 24);
        check("R6 div_clk copies enable", be, 0);
        base_pat = ep;
    endtask

    task automatic t_scaled();
        int e, d, br, be; logic [63:0] ep, dp;
        start_n(mk(1, 0, 8'h40, 8'h10));
        sample_n(26, e, d, br, be, ep, dp);
        check("R3 scaled 12/13 count", e, 24);
        check_pat("R3 scaled pattern equals unscaled", ep, base_pat);
    endtask

    task automatic t_quarter();
        int e, d, br, be; logic [63:0] ep, dp;
        start_n(mk(1, 0, 8'hFF, 8'h03));
        sample_n(8, e, d, br, be, ep, dp);
        check_pat("R2 1/4 pattern", ep, 64'b10001000);
        check("R6 pulse mode div equals en", be, 0);
    endtask

    task automatic t_stop();
        int e, d, br, be; logic [63:0] ep, dp;
        start_n(mk(1, 0, 8'hFF, 8'h03));
        sample_n(6, e, d, br, be, ep, dp);
        @(negedge clk) cfg_n = mk(0, 0, 8'hFF, 8'h03);
        sample_n(10, e, d, br, be, ep, dp);
        check("R4 enable low while stopped", e, 0);
        check("R4 div low while stopped", d, 0);
        @(negedge clk) cfg_n = mk(1, 0, 8'hFF, 8'h03);
        sample_n(4, e, d, br, be, ep, dp);
        check_pat("R4 restart from phase zero", ep, 64'b1000);
    endtask

    task automatic t_frozen();
        int e, d, br, be; logic [63:0] ep, dp;
        start_n(mk(1, 0, 8'hFF, 8'h03));
        sample_n(4, e, d, br, be, ep, dp);
        @(negedge clk) cfg_n = mk(1, 1, 8'hFF, 8'h00);
        sample_n(8, e, d, br, be, ep, dp);
        check("R5 rate unchanged by live rewrite", e, 2);
        check("R5 stretch not picked up while running", be, 0);
        @(negedge clk) cfg_n = mk(0, 1, 8'hFF, 8'h00);
        @(negedge clk) cfg_n = mk(1, 1, 8'hFF, 8'h00);
        sample_n(4, e, d, br, be, ep, dp);
        check("R5 new config used after stop", e, 4);
    endtask

    task automatic t_stretch();
        int e, d, br, be; logic [63:0] ep, dp;
        start_n(mk(1, 1, 8'hFF, 8'h03));
        sample_n(8, e, d, br, be, ep, dp);
        check_pat("R8 1/4 stretched pattern", dp, 64'b11001100);
        check("R7 rises only with enable 1/4", br, 0);
        start_n(mk(1, 1, 8'hF4, 8'h01));
        sample_n(13, e, d, br, be, ep, dp);
        check("R8 12/13 high time", d, 7);
        check("R2 12/13 pulses in stretch mode", e, 12);
        check("R7 rises only with enable 12/13", br, 0);
        start_n(mk(1, 1, 8'hFD, 8'h05));
        sample_n(16, e, d, br, be, ep, dp);
        check("R8 3/8 high time", d, 8);
        check("R2 3/8 pulses", e, 6);
        check("R7 rises only with enable 3/8", br, 0);
    endtask

    task automatic t_wide();
        int e;
        start_w(mkw(1, 0, 13'd8187, 13'd3));
        sample_w(16, e);
        check("R9 wide 5/8 pulses", e, 10);
        start_w(mkw(1, 0, 13'd3072, 13'd3072));
        sample_w(16, e);
        check("R9 R3 wide scaled 5/8 pulses", e, 10);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: all requirements, actual timeout expected completion");
        summary();
    end

    initial begin
        repeat (3) @(posedge clk);
        t_reset();
        t_rate();
        t_scaled();
        t_quarter();
        t_stop();
        t_frozen();
        t_stretch();
        t_wide();
        summary();
    end
endmodule